// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This unit holds two or three independent 32-bit down-counters that share one input clock and one small register space. Each channel owns a reload-constant register, a live counter and a control register. The control register picks a prescale divide, enables an underflow interrupt and carries a sticky underflow flag. One shared run register holds a single run bit per channel. When a counter is at zero and a prescaled tick arrives, it loads its constant and raises its flag. That makes each channel a periodic or a one-shot event source, and a free-running counter when the constant is all ones.

Software reaches every register through a single-cycle write strobe and a combinational read port, with byte addresses. Each channel runs a two-state machine. In `CH_HALT` the counter holds and the prescaler phase is cleared. In `CH_RUN` the prescaler advances and ticks decrement the counter. The START transition (`CH_HALT` to `CH_RUN`) is taken on the first clock that sees the channel's run bit set. The STOP transition (`CH_RUN` to `CH_HALT`) is taken on the first clock that sees it clear.

Top module: `tmr_unit`

## Requirements
- R1: After reset all run bits are 0, every counter and every constant reads 0xFFFFFFFF, every control register reads 0, and every interrupt line is low.
- R2: In the default variant the run register is at byte address 4, and channel n's constant, counter and control registers are at 8+12n, 12+12n and 16+12n. In the alternate variant the run register is at 2, and channel n's registers are at 4+12n, 8+12n and 12+12n. An address that maps to no register reads 0.
- R3: Bit n of the run register runs channel n. Written bits at or above the channel count are dropped and read back as 0.
- R4: Control bits 2:0 select the divide: 0 gives /4, 1 gives /16, 2 gives /64, 3 gives /256, and 4 to 7 give /1024. If the clock edge that sets a run bit is edge W, the first decrement happens at edge W+1+D, and each later one follows D edges after the one before.
- R5: While a channel's run bit is 0, its counter holds its value.
- R6: A tick that arrives while the counter is 0 loads the constant into the counter and sets the flag (control bit 8) on the same edge. The reload uses the constant that was held before that edge.
- R7: The flag is sticky. A control write with bit 8 at 0 clears it, and a control write with bit 8 at 1 leaves it as it is. A read has no side effect. If an underflow and a clearing write fall on the same edge, the flag ends up set.
- R8: irq[n] is high exactly when channel n's flag and its enable bit (control bit 5) are both 1.
- R9: Software may write the counter or the constant at any time, running or stopped. A counter write on the same edge as a tick wins, and counting then continues from the written value.
- R10: The prescaler phase restarts at every START, so a short run carries no partial phase into the next one.
- R11: Channels count independently, each at its own divide, and a channel that is not running is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all channels |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_addr | input | ADDR_W | Byte address of the register being accessed |
| bus_wdata | input | DW | Write data, low-aligned |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
Two situations are hard to reach: a counter write that lands on the very edge where a prescaled tick falls, and a stop/start pair that catches the prescaler part-way through a period. Both depend on the exact edge on which things happen, not on values. The bench drives every write one negedge before its edge and counts idle negedges between the start and the next write. With the R4 formula, this places the counter write on the third tick edge in one case, and in the other it stops a /4 channel three cycles into its phase, twice in a row. Underflow with the interrupt enabled and with it masked is reached by loading tiny counter values, so that the zero crossing happens within a few ticks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PH_W = 10;

    localparam int CTL_FLAG_BIT = 8;
    localparam int CTL_IE_BIT   = 5;

    typedef enum logic {
        CH_HALT = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    // Terminal phase value for a divide code.
    function automatic logic [PH_W-1:0] div_last(input logic [2:0] code);
        logic [PH_W-1:0] r;
        unique case (code)
            3'd0:    r = PH_W'(3);
            3'd1:    r = PH_W'(15);
            3'd2:    r = PH_W'(63);
            3'd3:    r = PH_W'(255);
            default: r = PH_W'(1023);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic [2:0] code,
    output logic       tick
);

    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] last;

    assign last = div_last(code);
    assign tick = en && (ph_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (clr) begin
            ph_q <= '0;
        end else if (en) begin
            if (ph_q >= last) ph_q <= '0;
            else              ph_q <= ph_q + PH_W'(1);
        end
    end

endmodule

// File: rtl/tmr_regdec.sv
module tmr_regdec #(
    parameter int NUM_CH  = 3,
    parameter int ADDR_W  = 6,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              run_hit,
    output logic [NUM_CH-1:0] cst_hit,
    output logic [NUM_CH-1:0] cnt_hit,
    output logic [NUM_CH-1:0] ctl_hit
);

    localparam int RUN_ADDR = ALT_MAP ? 2 : 4;
    localparam int CH0_BASE = ALT_MAP ? 4 : 8;
    localparam int CH_STEP  = 12;

    assign run_hit = (bus_addr == ADDR_W'(RUN_ADDR));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam int BASE = CH0_BASE + CH_STEP * i;
        assign cst_hit[i] = (bus_addr == ADDR_W'(BASE));
        assign cnt_hit[i] = (bus_addr == ADDR_W'(BASE + 4));
        assign ctl_hit[i] = (bus_addr == ADDR_W'(BASE + 8));
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cst_we,
    input  logic          cnt_we,
    input  logic          ctl_we,
    input  logic [DW-1:0] wdata,
    input  logic [2:0]    wdiv,
    input  logic          wie,
    input  logic          wflag,
    output logic [DW-1:0] cst_q,
    output logic [DW-1:0] cnt_q,
    output logic [2:0]    div_q,
    output logic          ie_q,
    output logic          flag_q,
    output logic          irq
);

    ch_state_e state_q, state_d;
    logic      tick;
    logic      uflow;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT;
        else        state_q <= state_d;
    end

    // transitions: START and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HALT: if (run)  state_d = CH_RUN;
            CH_RUN:  if (!run) state_d = CH_HALT;
            default: state_d = CH_HALT;
        endcase
    end

    tmr_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == CH_HALT),
        .en    ((state_q == CH_RUN) && run),
        .code  (div_q),
        .tick  (tick)
    );

    assign uflow = tick && (cnt_q == '0);

    // outputs: counter, constant, control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cst_q  <= '1;
            cnt_q  <= '1;
            div_q  <= 3'd0;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (cst_we) cst_q <= wdata;
            if (cnt_we)     cnt_q <= wdata;
            else if (uflow) cnt_q <= cst_q;
            else if (tick)  cnt_q <= cnt_q - DW'(1);
            if (ctl_we) begin
                div_q <= wdiv;
                ie_q  <= wie;
            end
            if (uflow)                 flag_q <= 1'b1;
            else if (ctl_we && !wflag) flag_q <= 1'b0;
        end
    end

    assign irq = flag_q & ie_q;

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int DW      = 32,
    parameter int ADDR_W  = 6,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic                       run_hit;
    logic [NUM_CH-1:0]          cst_hit, cnt_hit, ctl_hit;
    logic [NUM_CH-1:0]          cst_we, cnt_we, ctl_we;
    logic [NUM_CH-1:0]          run_q;
    logic [NUM_CH-1:0][DW-1:0]  cst_all, cnt_all;
    logic [NUM_CH-1:0][2:0]     div_all;
    logic [NUM_CH-1:0]          ie_v, flag_v;

    tmr_regdec #(
        .NUM_CH  (NUM_CH),
        .ADDR_W  (ADDR_W),
        .ALT_MAP (ALT_MAP)
    ) u_dec (
        .bus_addr (bus_addr),
        .run_hit  (run_hit),
        .cst_hit  (cst_hit),
        .cnt_hit  (cnt_hit),
        .ctl_hit  (ctl_hit)
    );

    assign cst_we = cst_hit & {NUM_CH{bus_we}};
    assign cnt_we = cnt_hit & {NUM_CH{bus_we}};
    assign ctl_we = ctl_hit & {NUM_CH{bus_we}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  run_q <= '0;
        else if (bus_we && run_hit)  run_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_channel #(.DW(DW)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_q[i]),
            .cst_we (cst_we[i]),
            .cnt_we (cnt_we[i]),
            .ctl_we (ctl_we[i]),
            .wdata  (bus_wdata),
            .wdiv   (bus_wdata[2:0]),
            .wie    (bus_wdata[CTL_IE_BIT]),
            .wflag  (bus_wdata[CTL_FLAG_BIT]),
            .cst_q  (cst_all[i]),
            .cnt_q  (cnt_all[i]),
            .div_q  (div_all[i]),
            .ie_q   (ie_v[i]),
            .flag_q (flag_v[i]),
            .irq    (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (run_hit) bus_rdata[NUM_CH-1:0] = run_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cst_hit[i]) bus_rdata = cst_all[i];
            if (cnt_hit[i]) bus_rdata = cnt_all[i];
            if (ctl_hit[i]) begin
                bus_rdata[2:0]          = div_all[i];
                bus_rdata[CTL_IE_BIT]   = ie_v[i];
                bus_rdata[CTL_FLAG_BIT] = flag_v[i];
            end
        end
    end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NUM_CH = 3,
    parameter int DW     = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_CH-1:0]         run_q,
    input logic [NUM_CH-1:0][DW-1:0] cnt_all,
    input logic [NUM_CH-1:0][DW-1:0] cst_all,
    input logic [NUM_CH-1:0]         flag,
    input logic [NUM_CH-1:0]         irq,
    input logic [NUM_CH-1:0]         cnt_we,
    input logic [NUM_CH-1:0]         cst_we,
    input logic [NUM_CH-1:0]         ctl_we,
    input logic                      wflag
);

    initial begin
        AST_CH_COUNT_LEGAL: assert (NUM_CH == 2 || NUM_CH == 3); // R11
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[i] && !cnt_we[i]) |=> $stable(cnt_all[i])); // R5

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_all[i] != '0 && !cnt_we[i]) |=>
            (cnt_all[i] == $past(cnt_all[i]) || cnt_all[i] == $past(cnt_all[i]) - DW'(1))); // R4

        AST_UFLOW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[i]) |-> ($past(cnt_all[i]) == '0)); // R6

        AST_RELOAD_CONST: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(flag[i]) && !$past(cnt_we[i]) && !$past(cst_we[i])) |->
            (cnt_all[i] == cst_all[i])); // R6

        AST_FLAG_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[i]) |-> ($past(ctl_we[i]) && !$past(wflag))); // R7

        AST_IRQ_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[i]) |-> $past(ctl_we[i])); // R8
    end

endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .cnt_all (cnt_all),
    .cst_all (cst_all),
    .flag    (flag_v),
    .irq     (irq),
    .cnt_we  (cnt_we),
    .cst_we  (cst_we),
    .ctl_we  (ctl_we),
    .wflag   (bus_wdata[8])
);

// File: tb/tb_tmr_unit.sv
`timescale 1ns/1ps
module tb_tmr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0, we2 = 1'b0;
    logic [5:0]  addr = '0, addr2 = '0;
    logic [31:0] wdata = '0, wdata2 = '0;
    logic [31:0] rdata, rdata2;
    logic [2:0]  irq;
    logic [1:0]  irq2;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    tmr_unit #(.NUM_CH(3), .DW(32), .ADDR_W(6), .ALT_MAP(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    tmr_unit #(.NUM_CH(2), .DW(32), .ADDR_W(6), .ALT_MAP(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .bus_we(we2), .bus_addr(addr2),
        .bus_wdata(wdata2), .bus_rdata(rdata2), .irq(irq2)
    );

    localparam logic [5:0] A_RUN = 6'd4;
    function automatic logic [5:0] a_cst(int n); return 6'(8 + 12*n);  endfunction
    function automatic logic [5:0] a_cnt(int n); return 6'(12 + 12*n); endfunction
    function automatic logic [5:0] a_ctl(int n); return 6'(16 + 12*n); endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Called at a negedge: write lands on the next posedge.
    task automatic wr(logic [5:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wr2(logic [5:0] a, logic [31:0] d);
        we2 = 1'b1; addr2 = a; wdata2 = d;
        @(negedge clk);
        we2 = 1'b0;
    endtask

    task automatic rd2(logic [5:0] a, output logic [31:0] d);
        addr2 = a;
        #1;
        d = rdata2;
    endtask

    task automatic idle(int m);
        repeat (m) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_RUN, v);     check("R1 run reg", v, 32'h0);
        rd(a_cst(0), v);  check("R1 ch0 constant", v, 32'hFFFF_FFFF);
        rd(a_cnt(2), v);  check("R1 ch2 counter", v, 32'hFFFF_FFFF);
        rd(a_ctl(1), v);  check("R1 ch1 control", v, 32'h0);
        check("R1 irq", {29'd0, irq}, 32'h0);
        rd(6'd0, v);      check("R2 unmapped addr 0", v, 32'h0);
        rd(6'd2, v);      check("R2 unmapped addr 2", v, 32'h0);
    endtask

    task automatic t_prescale;
        logic [31:0] v;
        wr(a_ctl(0), 32'h0); wr(a_cnt(0), 32'd100);
        wr(A_RUN, 32'h1); idle(40); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R4 div4 forty cycles", v, 32'd90);
        idle(20);
        rd(a_cnt(0), v); check("R5 hold while stopped", v, 32'd90);

        wr(a_ctl(0), 32'h1); wr(a_cnt(0), 32'd100);
        wr(A_RUN, 32'h1); idle(40); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R4 div16", v, 32'd98);

        wr(a_ctl(0), 32'h2); wr(a_cnt(0), 32'd100);
        wr(A_RUN, 32'h1); idle(130); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R4 div64", v, 32'd98);

        wr(a_ctl(0), 32'h6); wr(a_cnt(0), 32'd100);
        wr(A_RUN, 32'h1); idle(1030); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R4 code6 as div1024", v, 32'd99);
    endtask

    task automatic t_phase;
        logic [31:0] v;
        wr(a_ctl(0), 32'h0); wr(a_cnt(0), 32'd50);
        wr(A_RUN, 32'h1); idle(3); wr(A_RUN, 32'h0);
        wr(A_RUN, 32'h1); idle(3); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R10 phase restarts on start", v, 32'd50);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(a_ctl(0), 32'h20); wr(a_cst(0), 32'd5); wr(a_cnt(0), 32'd2);
        check("R8 irq low before underflow", {31'd0, irq[0]}, 32'd0);
        wr(A_RUN, 32'h1); idle(16); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R6 reload then one tick", v, 32'd4);
        rd(a_ctl(0), v); check("R6 flag set", v, 32'h120);
        check("R8 irq with enable", {31'd0, irq[0]}, 32'd1);
        wr(a_ctl(0), 32'h120);
        rd(a_ctl(0), v); check("R7 write one keeps flag", v, 32'h120);
        rd(a_ctl(0), v); check("R7 read no side effect", v, 32'h120);
        wr(a_ctl(0), 32'h020);
        rd(a_ctl(0), v); check("R7 write zero clears", v, 32'h020);
        check("R8 irq drops on clear", {31'd0, irq[0]}, 32'd0);
    endtask

    task automatic t_masked;
        logic [31:0] v;
        wr(a_ctl(0), 32'h0); wr(a_cst(0), 32'd9); wr(a_cnt(0), 32'd0);
        wr(A_RUN, 32'h1); idle(4); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R6 underflow from zero", v, 32'd9);
        rd(a_ctl(0), v); check("R6 flag only", v, 32'h100);
        check("R8 masked irq", {31'd0, irq[0]}, 32'd0);
        wr(a_ctl(0), 32'h120);
        check("R8 irq after enabling", {31'd0, irq[0]}, 32'd1);
        wr(a_ctl(0), 32'h0);
    endtask

    task automatic t_sw_write;
        logic [31:0] v;
        wr(a_ctl(0), 32'h0); wr(a_cnt(0), 32'd100);
        wr(A_RUN, 32'h1); idle(12); wr(a_cnt(0), 32'd500); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R9 write beats tick", v, 32'd500);
        wr(A_RUN, 32'h1); idle(8); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R9 resumes from written", v, 32'd498);
        wr(a_cst(0), 32'h1234);
        rd(a_cst(0), v); check("R9 constant write", v, 32'h1234);
    endtask

    task automatic t_channels;
        logic [31:0] v;
        wr(A_RUN, 32'hFF);
        rd(A_RUN, v); check("R3 upper run bits dropped", v, 32'h7);
        wr(A_RUN, 32'h0);
        wr(a_ctl(0), 32'h0); wr(a_cnt(0), 32'd100);
        wr(a_ctl(1), 32'h1); wr(a_cnt(1), 32'd100);
        wr(A_RUN, 32'h3); idle(32); wr(A_RUN, 32'h0);
        rd(a_cnt(0), v); check("R11 ch0 div4", v, 32'd92);
        rd(a_cnt(1), v); check("R11 ch1 div16", v, 32'd98);
        rd(a_cnt(2), v); check("R11 ch2 untouched", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_alt_map;
        logic [31:0] v;
        rd2(6'd2, v); check("R2 alt run reg reset", v, 32'h0);
        wr2(6'd8, 32'd77);
        rd2(6'd8, v); check("R2 alt ch0 counter", v, 32'd77);
        wr2(6'd16, 32'd33);
        rd2(6'd16, v); check("R2 alt ch1 constant", v, 32'd33);
        wr2(6'd2, 32'h1);
        rd2(6'd2, v); check("R2 alt run reg", v, 32'h1);
        wr2(6'd2, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prescale();
        t_phase();
        t_reload();
        t_masked();
        t_sw_write();
        t_channels();
        @(negedge clk);
        t_alt_map();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule